// File: doc/BRIEF.md
# Layered Window Pixel Compositor

This block merges five stacked rectangular windows into one output pixel stream. A raster source supplies the current X/Y position, an active-video flag and one 24-bit RGB sample per window for that position. The block decides which windows cover the position. It then folds their samples from the bottom layer upwards into a single colour. The result is registered once, so the output stream lags the raster by one clock.

Each window holds its own settings, programmed through a write-only port: an enable, an origin, an extent, and, for layers 1 to 4, a 4-bit weight per colour channel plus a transparent-colour match. Layer 0 is the base plane. It is always opaque and has no transparent colour.

Top module: `ovl_compositor`

## Requirements
- R1: After reset every window is disabled, `de_out` and `pix_out` are 0, each upper layer's channel weights are 0xF, and its transparent-colour match is off.
- R2: `de_out` equals the `de_in` of the previous clock, and `pix_out` is the composite of the inputs presented in that previous clock.
- R3: Whenever `de_out` is 0, `pix_out` is 0.
- R4: `cfg_addr[5:3]` selects the window and `cfg_addr[2:0]` selects the setting. The settings are:
  - 0: control, with bit 0 as enable and bit 1 as transparent-match enable.
  - 1: origin, with X in `cfg_wdata[11:0]` and Y in `cfg_wdata[27:16]`.
  - 2: extent, with the same field layout as the origin.
  - 3: weights, with R in bits [3:0], G in [7:4] and B in [11:8].
  - 4: match colour, in bits [23:0].

  Writes that name a window index of 5, 6 or 7 change nothing.
- R5: A window covers (x,y) exactly when origin ≤ position ≤ origin + extent − 1 on both axes, with both bounds inclusive.
- R6: When origin + extent on an axis is 0, the last covered coordinate on that axis is 0 rather than wrapping.
- R7: Higher window indices lie on top. Composition starts from the layer 0 sample where layer 0 is enabled and covers the position, and from black (0) otherwise.
- R8: Layer 0 is always fully opaque and never transparent. Writes to its weight or match-colour settings have no effect on the output.
- R9: A covering upper layer with weight a gives, per channel, floor((a·upper + (15−a)·lower)/15). Weight 0xF yields the upper sample unchanged.
- R10: When an upper layer's match is enabled and its sample equals the match colour, the colour beneath passes through unchanged.
- R11: A disabled window does not affect the output.
- Pixel packing: window i occupies `win_pix[24*i+23:24*i]`, with R in the top byte, G in the middle byte and B in the low byte. The output uses the same packing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 6 | Window index and setting select |
| cfg_wdata | input | 32 | Setting write data |
| pix_x | input | 12 | Current raster column |
| pix_y | input | 12 | Current raster row |
| de_in | input | 1 | Active-video flag for the current position |
| win_pix | input | 120 | One RGB sample per window, packed |
| pix_out | output | 24 | Composited RGB |
| de_out | output | 1 | Active-video flag delayed to match `pix_out` |

## Verification
The composite of the inputs presented before a rising edge appears on `pix_out` and `de_out` right after that edge, one clock later. A setting written at an edge is first used for the position sampled at the following edge, so its effect shows one clock later again. The bench drives every input on the falling edge and predicts the output from its own model of the settings as they stood before the edge. Only after predicting does it apply any write to the model. It compares on the next falling edge, every clock, so both delays are checked exactly.

// File: rtl/ovl_pkg.sv
// Shared types and sizes for the layered window compositor.
// Assumes five windows; layer 0 is the opaque base plane.
package ovl_pkg;
    localparam int NUM_WIN   = 5;
    localparam int WIN_IDX_W = 3;
    localparam int REG_SEL_W = 3;
    localparam int ADDR_W    = WIN_IDX_W + REG_SEL_W;
    localparam int PIX_W     = 24;

    typedef enum logic [REG_SEL_W-1:0] {
        SEL_CTRL  = 3'd0,
        SEL_ORIG  = 3'd1,
        SEL_SIZE  = 3'd2,
        SEL_ALPHA = 3'd3,
        SEL_KEY   = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    typedef struct packed {
        logic [3:0] b;
        logic [3:0] g;
        logic [3:0] r;
    } alpha_t;
endpackage

// File: rtl/ovl_win_regs.sv
// Setting store for one window. It keeps the enable, the origin and the extent,
// and derives the inclusive last coordinate, which saturates at 0. When
// HAS_BLEND is 0 (the base plane) the weights read as 0xF and the match is
// off, and writes to those settings are dropped.
// Assumes wr_en is already decoded for this window and that CW <= 16.
module ovl_win_regs
    import ovl_pkg::*;
#(
    parameter int CW        = 12,
    parameter bit HAS_BLEND = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_SEL_W-1:0] wr_sel,
    input  logic [31:0]          wr_data,
    output logic                 en,
    output logic                 key_en,
    output logic [CW-1:0]        tl_x,
    output logic [CW-1:0]        tl_y,
    output logic [CW:0]          br_x,
    output logic [CW:0]          br_y,
    output alpha_t               alpha,
    output rgb_t                 key
);
    localparam int YLSB = 16;

    logic [CW-1:0] siz_x, siz_y;
    logic          wr_unused;

    assign wr_unused = ^wr_data;

    function automatic logic [CW:0] last_coord(input logic [CW-1:0] s, input logic [CW-1:0] n);
        logic [CW:0] sum;
        sum = {1'b0, s} + {1'b0, n};
        return (sum == '0) ? '0 : sum - 1'b1;
    endfunction

    // Purpose: hold the enable and the rectangle settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en    <= 1'b0;
            tl_x  <= '0;
            tl_y  <= '0;
            siz_x <= '0;
            siz_y <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CTRL: en <= wr_data[0];
                SEL_ORIG: begin
                    tl_x <= wr_data[CW-1:0];
                    tl_y <= wr_data[YLSB+CW-1:YLSB];
                end
                SEL_SIZE: begin
                    siz_x <= wr_data[CW-1:0];
                    siz_y <= wr_data[YLSB+CW-1:YLSB];
                end
                default: ;
            endcase
        end
    end

    // Purpose: inclusive last coordinate per axis, clamped at zero.
    always_comb begin
        br_x = last_coord(tl_x, siz_x);
        br_y = last_coord(tl_y, siz_y);
    end

    generate
        if (HAS_BLEND) begin : g_blend
            // Purpose: hold the channel weights, the match enable and the match colour.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    alpha  <= '{b: 4'hF, g: 4'hF, r: 4'hF};
                    key_en <= 1'b0;
                    key    <= '0;
                end else if (wr_en) begin
                    case (wr_sel)
                        SEL_CTRL:  key_en <= wr_data[1];
                        SEL_ALPHA: alpha  <= wr_data[11:0];
                        SEL_KEY:   key    <= wr_data[PIX_W-1:0];
                        default: ;
                    endcase
                end
            end
        end else begin : g_base
            assign alpha  = '{b: 4'hF, g: 4'hF, r: 4'hF};
            assign key_en = 1'b0;
            assign key    = '0;
        end
    endgenerate

    // R4: a control write sets the enable seen on the next clock.
    p_ctrl_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL) |=> (en == $past(wr_data[0])));
endmodule

// File: rtl/ovl_blend_stage.sv
// One layer of the composite chain. It applies the transparent-colour match,
// then the per-channel weighted mix of this layer's sample over the colour
// beneath. Purely combinational.
// Assumes the weight is 0..15, where 15 means opaque.
module ovl_blend_stage
    import ovl_pkg::*;
(
    input  rgb_t   lower,
    input  rgb_t   upper,
    input  logic   hit,
    input  logic   key_en,
    input  rgb_t   key,
    input  alpha_t alpha,
    output rgb_t   result,
    output logic   keyed
);
    function automatic logic [7:0] mix8(input logic [3:0] a, input logic [7:0] u, input logic [7:0] l);
        logic [11:0] s;
        logic [11:0] q;
        s = 12'(a) * 12'(u) + 12'(4'd15 - a) * 12'(l);
        q = s / 12'd15;
        return q[7:0];
    endfunction

    // Purpose: select pass-through or weighted mix for this layer.
    always_comb begin
        keyed = hit && key_en && (upper == key);
        if (hit && !keyed) begin
            result.r = mix8(alpha.r, upper.r, lower.r);
            result.g = mix8(alpha.g, upper.g, lower.g);
            result.b = mix8(alpha.b, upper.b, lower.b);
        end else begin
            result = lower;
        end
    end
endmodule

// File: rtl/ovl_compositor.sv
// Five-layer window compositor. It decodes setting writes per window, tests
// each window's inclusive rectangle against the raster position, folds the
// layers from 0 upwards, and registers the result with the active-video flag.
// Assumes samples are aligned with pix_x/pix_y/de_in in the same cycle.
module ovl_compositor
    import ovl_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [31:0]              cfg_wdata,
    input  logic [CW-1:0]            pix_x,
    input  logic [CW-1:0]            pix_y,
    input  logic                     de_in,
    input  logic [NUM_WIN*PIX_W-1:0] win_pix,
    output logic [PIX_W-1:0]         pix_out,
    output logic                     de_out
);
    logic [WIN_IDX_W-1:0] wr_win;
    logic [REG_SEL_W-1:0] wr_sel;
    logic [NUM_WIN-1:0]   en_v, ken_v, hit_v, keyed_v;
    logic [CW-1:0]        tl_x [NUM_WIN];
    logic [CW-1:0]        tl_y [NUM_WIN];
    logic [CW:0]          br_x [NUM_WIN];
    logic [CW:0]          br_y [NUM_WIN];
    alpha_t               alpha_v [NUM_WIN];
    rgb_t                 key_v [NUM_WIN];
    rgb_t                 samp [NUM_WIN];
    rgb_t                 layer [NUM_WIN+1];
    rgb_t                 out_q;
    logic                 de_q;

    assign wr_win   = cfg_addr[ADDR_W-1:REG_SEL_W];
    assign wr_sel   = cfg_addr[REG_SEL_W-1:0];
    assign layer[0] = '0;

    generate
        for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
            ovl_win_regs #(.CW(CW), .HAS_BLEND(i != 0)) u_regs (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (cfg_we && (wr_win == WIN_IDX_W'(i))),
                .wr_sel  (wr_sel),
                .wr_data (cfg_wdata),
                .en      (en_v[i]),
                .key_en  (ken_v[i]),
                .tl_x    (tl_x[i]),
                .tl_y    (tl_y[i]),
                .br_x    (br_x[i]),
                .br_y    (br_y[i]),
                .alpha   (alpha_v[i]),
                .key     (key_v[i])
            );

            assign samp[i] = win_pix[PIX_W*i +: PIX_W];

            // Purpose: inclusive rectangle coverage of the current position.
            always_comb begin
                hit_v[i] = en_v[i]
                    && (pix_x >= tl_x[i]) && ({1'b0, pix_x} <= br_x[i])
                    && (pix_y >= tl_y[i]) && ({1'b0, pix_y} <= br_y[i]);
            end

            ovl_blend_stage u_stage (
                .lower  (layer[i]),
                .upper  (samp[i]),
                .hit    (hit_v[i]),
                .key_en (ken_v[i]),
                .key    (key_v[i]),
                .alpha  (alpha_v[i]),
                .result (layer[i+1]),
                .keyed  (keyed_v[i])
            );

            // R10: a matched sample leaves the colour beneath untouched.
            p_key_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
                keyed_v[i] |-> (layer[i+1] == layer[i]));

            // R9: full weight on a covering, unmatched layer yields its own sample.
            p_opaque_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (hit_v[i] && !keyed_v[i] && alpha_v[i] == 12'hFFF) |-> (layer[i+1] == samp[i]));
        end
    endgenerate

    // Purpose: output register with matching active-video delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_q  <= 1'b0;
            out_q <= '0;
        end else begin
            de_q  <= de_in;
            out_q <= de_in ? layer[NUM_WIN] : '0;
        end
    end

    assign pix_out = out_q;
    assign de_out  = de_q;

    // R2: the qualifier lags the input by exactly one clock.
    p_de_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (de_out == $past(de_in)));

    // R3: blank output outside active video.
    p_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !de_out |-> (pix_out == '0));

    // R11: with every window off the active output is black.
    p_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(de_in) && $past(en_v) == '0) |-> (pix_out == '0));
endmodule

// File: tb/sim_ovl_compositor.sv
`timescale 1ns/1ps
module sim_ovl_compositor;
    localparam int  CW   = 12;
    localparam real HALF = 2.5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [5:0]   cfg_addr = '0;
    logic [31:0]  cfg_wdata = '0;
    logic [CW-1:0] pix_x = '0, pix_y = '0;
    logic         de_in = 1'b0;
    logic [119:0] win_pix = '0;
    logic [23:0]  pix_out;
    logic         de_out;

    int checks = 0, errors = 0;
    int m_en[5], m_ken[5], m_ox[5], m_oy[5], m_sx[5], m_sy[5];
    int m_ar[5], m_ag[5], m_ab[5], m_key[5];

    always #(HALF) clk = ~clk;

    ovl_compositor #(.CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_x(pix_x), .pix_y(pix_y), .de_in(de_in),
        .win_pix(win_pix), .pix_out(pix_out), .de_out(de_out)
    );

    function automatic int pixval(int w, int x, int y);
        return (((w*53 + x*17 + y*29) & 255) << 16)
             | (((w*11 + x*7 + y*3 + 40) & 255) << 8)
             | ((x*y + w*90) & 255);
    endfunction

    function automatic int last_c(int s, int n);
        return (s + n == 0) ? 0 : s + n - 1;
    endfunction

    function automatic int mixc(int a, int u, int l);
        return (a*u + (15-a)*l) / 15;
    endfunction

    function automatic int model_out(int x, int y);
        int r = 0, g = 0, b = 0;
        for (int w = 0; w < 5; w++) begin
            int p;
            if (m_en[w] == 0) continue;
            if (x < m_ox[w] || x > last_c(m_ox[w], m_sx[w])) continue;
            if (y < m_oy[w] || y > last_c(m_oy[w], m_sy[w])) continue;
            p = pixval(w, x, y);
            if (m_ken[w] != 0 && p == m_key[w]) continue;
            r = mixc(m_ar[w], (p >> 16) & 255, r);
            g = mixc(m_ag[w], (p >> 8) & 255, g);
            b = mixc(m_ab[w], p & 255, b);
        end
        return (r << 16) | (g << 8) | b;
    endfunction

    task automatic model_reset();
        for (int w = 0; w < 5; w++) begin
            m_en[w] = 0; m_ken[w] = 0; m_ox[w] = 0; m_oy[w] = 0;
            m_sx[w] = 0; m_sy[w] = 0; m_ar[w] = 15; m_ag[w] = 15;
            m_ab[w] = 15; m_key[w] = 0;
        end
    endtask

    task automatic model_write(int a, int d);
        int w = a >> 3;
        int s = a & 7;
        if (w >= 5) return;
        case (s)
            0: begin m_en[w] = d & 1; if (w > 0) m_ken[w] = (d >> 1) & 1; end
            1: begin m_ox[w] = d & 'hFFF; m_oy[w] = (d >> 16) & 'hFFF; end
            2: begin m_sx[w] = d & 'hFFF; m_sy[w] = (d >> 16) & 'hFFF; end
            3: if (w > 0) begin m_ar[w] = d & 15; m_ag[w] = (d >> 4) & 15; m_ab[w] = (d >> 8) & 15; end
            4: if (w > 0) m_key[w] = d & 'hFFFFFF;
            default: ;
        endcase
    endtask

    // One clock: drive at falling edge, predict, update model at the rising edge, compare.
    task automatic cyc(logic we, int a, int d, logic de, int x, int y, string tag);
        int exp_pix;
        logic exp_de;
        cfg_we = we; cfg_addr = a[5:0]; cfg_wdata = d;
        de_in = de; pix_x = x[CW-1:0]; pix_y = y[CW-1:0];
        for (int w = 0; w < 5; w++) win_pix[24*w +: 24] = pixval(w, x, y);
        exp_de  = de;
        exp_pix = de ? model_out(x, y) : 0;
        @(posedge clk);
        if (we) model_write(a, d);
        @(negedge clk);
        checks++;
        if (pix_out !== exp_pix[23:0] || de_out !== exp_de) begin
            errors++;
            $display("FAIL %s at (%0d,%0d): pix %06h de %b, expected pix %06h de %b",
                     tag, x, y, pix_out, de_out, exp_pix[23:0], exp_de);
        end
    endtask

    task automatic wr(int a, int d);
        cyc(1'b1, a, d, 1'b0, 0, 0, "R4");
    endtask

    task automatic scan(string tag);
        for (int y = 0; y < 10; y++) begin
            for (int x = 0; x < 12; x++) cyc(1'b0, 0, 0, 1'b1, x, y, tag);
            cyc(1'b0, 0, 0, 1'b0, 0, y, "R3");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (pix_out !== 24'h0 || de_out !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs: pix %06h de %b, expected 000000 0", pix_out, de_out);
        end
        scan("R11");                        // R1/R11: nothing enabled -> black
        wr(1, 32'h0);                       // layer 0 full raster
        wr(2, (10 << 16) | 12);
        wr(0, 1);
        scan("R7");                         // R7: base plane alone
        wr(3, 0);                           // R8: base weight/match writes ignored
        wr(4, pixval(0, 2, 2));
        wr(0, 3);
        scan("R8");
        wr(8 + 1, (4 << 16) | 3);           // R5: layer 1 covers x 3..6, y 4..6
        wr(8 + 2, (3 << 16) | 4);
        wr(8 + 0, 1);
        scan("R5");                         // also R1: weights reset to 0xF
        wr(8 + 3, 'hC37);                   // R9: mixed weights
        scan("R9");
        wr(16 + 1, (2 << 16) | 2);          // R10: layer 2 with match colour
        wr(16 + 2, (6 << 16) | 6);
        wr(16 + 4, pixval(2, 5, 5));
        wr(16 + 0, 3);
        scan("R10");
        wr(24 + 1, 0);                      // R6: zero origin and extent -> only (0,0)
        wr(24 + 2, 0);
        wr(24 + 0, 1);
        scan("R6");
        wr(32 + 1, 5);                      // R7: top layer over the rest
        wr(32 + 2, (10 << 16) | 3);
        wr(32 + 3, 'h999);
        wr(32 + 0, 1);
        scan("R7");
        wr(16 + 0, 0);                      // R11: disable layer 2
        scan("R11");
        wr(48 + 0, 3);                      // R4: windows 6 and 7 do not exist
        wr(48 + 1, 0);
        wr(56 + 2, 0);
        wr(40 + 0, 0);
        scan("R4");
        for (int k = 0; k < 40; k++)        // R2/R3: toggling active video
            cyc(1'b0, 0, 0, logic'(k % 3 != 0), k % 12, k % 10, (k % 3 != 0) ? "R2" : "R3");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule